// File: doc/BRIEF.md
# Timer with Compare Match Unit

An 8-bit up-counter that runs from zero to a programmable period value and then returns to zero. Three channel compare registers are tested against the counter on every clock. When the counter steps onto a channel's value, that channel gives a one-cycle match strobe. One cycle later the strobe sets the channel's sticky interrupt flag, and that flag stays set until software clears it.

Software reaches the counter, the period register, the flag bits and the compare registers over a simple word-wide register port. A write lands on the next clock, and a read is combinational. A match comes only from counting. A bus write that loads the counter, or that changes a compare value to the one the counter already holds, makes no match. Period writes below three are raised to three.

Top module: `timer_cmp_unit`

## Requirements
- R1: After reset the counter reads 0, the period register reads 0xFF, every compare register reads 0x00 and every flag is 0.
- R2: When `cntEn` is high and no counter write is present, the counter increases by one on each clock. When `cntEn` is low, the counter holds its value.
- R3: An enabled clock on which the counter equals the period value sets the counter to 0 on the next cycle.
- R4: A period write with a value below 3 stores 3. Any other value is stored unchanged.
- R5: A counter write (address 0) loads the written value on the next clock in place of that clock's increment. No match strobe is raised in the cycle that follows the write.
- R6: `matchPulse[i]` is high for exactly the cycle in which the counter has just been advanced (by increment or wrap) onto compare register i's value.
- R7: A counter value that is held, or a compare register written to equal the held counter, gives no match strobe and sets no flag.
- R8: `irqFlag[i]` goes high on the cycle after `matchPulse[i]` and stays high until it is cleared.
- R9: Writing to the flag address clears each flag whose data bit is 1 (bit i is channel i). A data bit of 0 leaves that flag as it is. A match and a clear on the same cycle leave the flag set.
- R10: Register map: 0 counter, 1 period, 2 flags, 3+i compare channel i. Reads are combinational. An unmapped address reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the counter and the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| cntEn | input | 1 | Count enable for this clock |
| busWe | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register address |
| busWdata | input | CNT_W | Write data |
| busRdata | output | CNT_W | Read data for `busAddr` |
| matchPulse | output | NUM_CH | One-cycle match strobe per channel |
| irqFlag | output | NUM_CH | Sticky interrupt flag per channel |

## Verification
Reads are due in the same cycle the address is driven. A register or counter write shows one cycle after the write cycle. A match strobe appears in the cycle the counter holds the advanced value, and the flag follows one cycle after that. The driver gives every expected item an absolute cycle number computed from these delays. The monitor compares each item 3 ns after the falling edge of exactly that cycle, once all inputs have been stable for that clock.

// File: rtl/timer_cmp_pkg.sv
package timer_cmp_pkg;
  localparam int ADDR_CNT  = 0;
  localparam int ADDR_PER  = 1;
  localparam int ADDR_FLAG = 2;
  localparam int CMP_BASE  = 3;

  typedef struct packed {
    logic cntWr;
    logic perWr;
    logic flagWr;
    logic advance;
  } ctrlStrobes_t;
endpackage

// File: rtl/timer_cmp_ctrl.sv
module timer_cmp_ctrl
  import timer_cmp_pkg::*;
#(
  parameter int ADDR_W = 3,
  parameter int NUM_CH = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output ctrlStrobes_t      strobes,
  output logic [NUM_CH-1:0] cmpWe
);
  always_comb begin
    strobes.cntWr   = busWe && (busAddr == ADDR_W'(ADDR_CNT));
    strobes.perWr   = busWe && (busAddr == ADDR_W'(ADDR_PER));
    strobes.flagWr  = busWe && (busAddr == ADDR_W'(ADDR_FLAG));
    // a counter load takes the place of the increment
    strobes.advance = cntEn && !strobes.cntWr;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gCmpDec
    assign cmpWe[g] = busWe && (busAddr == ADDR_W'(CMP_BASE + g));
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.cntWr, strobes.perWr, strobes.flagWr, cmpWe})); // R10
endmodule

// File: rtl/timer_cmp_datapath.sv
module timer_cmp_datapath
  import timer_cmp_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NUM_CH     = 3,
  parameter int ADDR_W     = 3,
  parameter int PERIOD_MIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [NUM_CH-1:0] cmpWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] matchPulse,
  output logic [NUM_CH-1:0] irqFlag
);
  localparam logic [CNT_W-1:0] PER_RESET = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(PERIOD_MIN);

  logic [CNT_W-1:0]  cntReg;
  logic [CNT_W-1:0]  perReg;
  logic [CNT_W-1:0]  cmpReg [NUM_CH];
  logic              cntMoved;
  logic [NUM_CH-1:0] flagReg;
  logic [NUM_CH-1:0] clrMask;
  logic [CNT_W-1:0]  perNext;

  assign perNext = (busWdata < PER_FLOOR) ? PER_FLOOR : busWdata;

  // counter: a load wins over counting, the period value wraps to zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntReg   <= '0;
      cntMoved <= 1'b0;
    end else begin
      cntMoved <= strobes.advance;
      if (strobes.cntWr)
        cntReg <= busWdata;
      else if (strobes.advance)
        cntReg <= (cntReg == perReg) ? '0 : cntReg + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              perReg <= PER_RESET;
    else if (strobes.perWr) perReg <= perNext;
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : gChan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)         cmpReg[g] <= '0;
      else if (cmpWe[g]) cmpReg[g] <= busWdata;
    end
    // a match only counts when the counter stepped onto the value
    assign matchPulse[g] = cntMoved && (cntReg == cmpReg[g]);

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rstN)
      matchPulse[g] |=> irqFlag[g]); // R8
    AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (!rstN)
      (irqFlag[g] && !(strobes.flagWr && busWdata[g])) |=> irqFlag[g]); // R9
  end

  assign clrMask = strobes.flagWr ? busWdata[NUM_CH-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagReg <= '0;
    else       flagReg <= (flagReg & ~clrMask) | matchPulse;
  end
  assign irqFlag = flagReg;

  always_comb begin
    busRdata = '0;
    if (busAddr == ADDR_W'(ADDR_CNT))       busRdata = cntReg;
    else if (busAddr == ADDR_W'(ADDR_PER))  busRdata = perReg;
    else if (busAddr == ADDR_W'(ADDR_FLAG)) busRdata = CNT_W'(flagReg);
    for (int i = 0; i < NUM_CH; i++)
      if (busAddr == ADDR_W'(CMP_BASE + i)) busRdata = cmpReg[i];
  end

  AST_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && cntReg != perReg) |=> cntReg == $past(cntReg) + CNT_W'(1)); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.advance && !strobes.cntWr) |=> $stable(cntReg)); // R2
  AST_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.advance && cntReg == perReg) |=> cntReg == '0); // R3
  AST_PERIOD_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
    perReg >= PER_FLOOR); // R4
  AST_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntWr |=> cntReg == $past(busWdata)); // R5
  AST_NO_MATCH_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.cntWr |=> matchPulse == '0); // R5
endmodule

// File: rtl/timer_cmp_unit.sv
module timer_cmp_unit
  import timer_cmp_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int NUM_CH     = 3,
  parameter int ADDR_W     = 3,
  parameter int PERIOD_MIN = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cntEn,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [CNT_W-1:0]  busWdata,
  output logic [CNT_W-1:0]  busRdata,
  output logic [NUM_CH-1:0] matchPulse,
  output logic [NUM_CH-1:0] irqFlag
);
  ctrlStrobes_t      strobes;
  logic [NUM_CH-1:0] cmpWe;

  timer_cmp_ctrl #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .busWe(busWe), .busAddr(busAddr),
    .strobes(strobes), .cmpWe(cmpWe)
  );

  timer_cmp_datapath #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W),
                       .PERIOD_MIN(PERIOD_MIN)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .cmpWe(cmpWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .matchPulse(matchPulse), .irqFlag(irqFlag)
  );
endmodule

// File: tb/timer_cmp_unit_bench.sv
`timescale 1ns/1ps
module timer_cmp_unit_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cntEn = 1'b0;
  logic       busWe = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [2:0] matchPulse;
  logic [2:0] irqFlag;

  timer_cmp_unit u_timer_cmp_unit (
    .clk(clk), .rstN(rstN), .cntEn(cntEn), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .matchPulse(matchPulse), .irqFlag(irqFlag)
  );

  always #4 clk = ~clk;

  int cycleCnt = 0;
  always @(posedge clk) cycleCnt = cycleCnt + 1;

  // kind 0: busRdata, 1: matchPulse, 2: irqFlag
  typedef struct {
    string req;
    int    kind;
    int    due;
    int    val;
  } expItem_t;
  expItem_t q[$];
  int checks = 0;
  int errors = 0;
  bit driverDone = 0;

  task automatic expect_at(input string req, input int kind, input int due, input int val);
    expItem_t it;
    it.req = req; it.kind = kind; it.due = due; it.val = val;
    q.push_back(it);
  endtask

  task automatic drive(input int c, input logic en, input logic we,
                       input int addr, input int data);
    while (cycleCnt < c) @(negedge clk);
    cntEn = en; busWe = we; busAddr = 3'(addr); busWdata = 8'(data);
  endtask

  // monitor: compares queued items in their due cycle
  initial begin
    forever begin
      @(negedge clk);
      #3;
      while (q.size() > 0 && q[0].due <= cycleCnt) begin
        expItem_t it;
        int got;
        it = q.pop_front();
        got = (it.kind == 0) ? int'(busRdata) : (it.kind == 1) ? int'(matchPulse) : int'(irqFlag);
        checks++;
        if (it.due != cycleCnt || got != it.val) begin
          errors++;
          $display("FAIL %s cycle %0d kind %0d: actual %0d expected %0d",
                   it.req, cycleCnt, it.kind, got, it.val);
        end
      end
    end
  end

  initial begin
    int b, n;
    b = 5;
    n = b + 13;
    drive(3, 0, 0, 0, 0);
    rstN = 1'b1;
    // reset state (R1)
    expect_at("R1", 0, b, 0);
    expect_at("R1", 0, b + 1, 255);
    expect_at("R1", 0, b + 2, 0);
    expect_at("R1", 2, b + 2, 0);
    expect_at("R1", 0, b + 3, 0);
    expect_at("R4", 0, b + 5, 3);
    expect_at("R10", 0, b + 10, 16);
    expect_at("R10", 0, b + 11, 0);
    expect_at("R10", 0, b + 12, 16);
    drive(b,     0, 0, 0, 0);
    drive(b + 1, 0, 0, 1, 0);
    drive(b + 2, 0, 0, 2, 0);
    drive(b + 3, 0, 0, 3, 0);
    drive(b + 4, 0, 1, 1, 1);      // period <- 1, clamps to 3
    drive(b + 5, 0, 0, 1, 0);
    drive(b + 6, 0, 1, 1, 16);
    drive(b + 7, 0, 1, 3, 5);      // cmp0
    drive(b + 8, 0, 1, 4, 16);     // cmp1 equals period
    drive(b + 9, 0, 1, 5, 0);      // cmp2 = 0
    drive(b + 10, 0, 0, 1, 0);
    drive(b + 11, 0, 1, 7, 9);     // unmapped write
    drive(b + 12, 0, 0, 4, 0);
    // counting phase
    expect_at("R7", 1, n, 0);            // held zero equals cmp2: no match
    expect_at("R2", 0, n + 3, 3);
    expect_at("R6", 1, n + 4, 0);
    expect_at("R6", 1, n + 5, 1);
    expect_at("R8", 2, n + 6, 1);
    expect_at("R6", 1, n + 16, 2);
    expect_at("R2", 0, n + 16, 16);
    expect_at("R3", 0, n + 17, 0);
    expect_at("R6", 1, n + 17, 4);
    expect_at("R8", 2, n + 18, 7);
    expect_at("R2", 0, n + 20, 3);
    expect_at("R9", 2, n + 22, 6);
    expect_at("R9", 2, n + 23, 6);
    expect_at("R7", 1, n + 24, 0);
    expect_at("R2", 0, n + 24, 3);
    expect_at("R7", 2, n + 25, 6);
    expect_at("R5", 0, n + 26, 2);
    expect_at("R5", 1, n + 26, 0);
    expect_at("R6", 1, n + 27, 1);
    expect_at("R9", 2, n + 28, 7);
    expect_at("R5", 0, n + 29, 16);
    expect_at("R5", 1, n + 29, 0);
    expect_at("R3", 0, n + 30, 0);
    expect_at("R3", 1, n + 30, 4);
    expect_at("R4", 0, n + 32, 3);
    drive(n,      1, 0, 0, 0);
    drive(n + 20, 0, 0, 0, 0);
    drive(n + 21, 0, 1, 2, 1);     // clear flag 0
    drive(n + 22, 0, 1, 2, 0);     // zero write: no change
    drive(n + 23, 0, 1, 3, 3);     // cmp0 <- held count
    drive(n + 24, 0, 0, 0, 0);
    drive(n + 25, 0, 1, 0, 2);     // load counter
    drive(n + 26, 1, 0, 0, 0);
    drive(n + 27, 0, 1, 2, 1);     // clear flag 0 while it matches
    drive(n + 28, 1, 1, 0, 16);    // load beats increment
    drive(n + 29, 1, 0, 0, 0);
    drive(n + 30, 0, 0, 0, 0);
    drive(n + 31, 0, 1, 1, 0);     // period <- 0, clamps to 3
    drive(n + 32, 0, 0, 1, 0);
    drive(n + 34, 0, 0, 0, 0);
    driverDone = 1;
  end

  initial begin
    while (!driverDone && cycleCnt < 5000) @(negedge clk);
    if (!driverDone) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    if (q.size() > 0) begin
      checks++;
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", q.size());
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule